// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a single-cycle strobe at sixteen times a serial line's bit rate from a free-running system clock. The divisor has two parts: an integer count of clocks and a binary fraction in 1/64 steps. A fraction cannot be counted directly, so the block alternates between intervals of N and N+1 clocks. It chooses between them with a small accumulator. Over any 64 consecutive intervals, the average spacing then equals the programmed divisor exactly. The resulting bit rate is f_clk / (16 × (N + F/64)).

For example, a 50 MHz clock with N = 27 and F = 8 gives a bit rate near 115200. An 8 MHz clock with N = 26 and F = 3 gives a rate near 19200. In both cases the error is far inside the few-percent tolerance that two asynchronous endpoints can absorb. Software writes the divisor inputs while `enable` is low. The block captures them on the rising edge of `enable` and ignores them after that until the next rising edge.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and afterwards until `enable` is first seen high, `tick` stays low.
- R2: Let E0 be the clock edge at which `enable` is first sampled high after being low. The first tick is high in the cycle that follows edge E0+N, where N is the captured integer divisor.
- R3: Each later interval between ticks is N or N+1 clocks. A 6-bit accumulator starts at zero and adds the captured fraction F at every tick. An interval is N+1 exactly when that addition carries out of 6 bits, so tick i (counting from 1) appears at edge E0 + i·N + floor((i−1)·F/64).
- R4: The span from the 1st to the 65th tick is exactly 64·N + F clocks.
- R5: When N ≥ 2, `tick` is never high in two consecutive cycles.
- R6: Changes to `div_int` or `div_frac` while `enable` stays high have no effect on tick timing. The values present at the next rising edge of `enable` take effect from that edge.
- R7: If `enable` is sampled low, `tick` is low from the next cycle on. A new rising edge of `enable` restarts both the interval count and the accumulator from zero.
- R8: A captured integer divisor of 0 produces no ticks while `enable` stays high.
- R9: With F = 0, ticks occur every N clocks exactly.
- R10: With N = 1 and F > 0, `tick` is high in every cycle except for a single low cycle after each accumulator carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; a rising edge captures the divisor |
| div_int | input | INT_W (16) | Integer part of the divisor, in clocks |
| div_frac | input | FRAC_W (6) | Fractional part of the divisor, in 1/64 units |
| tick | output | 1 | Strobe at 16× the bit rate |

## Verification
Two things can fall in the same cycle. One is the expiry of an interval together with the accumulator carry that stretches the next interval. The other is the capture of a divisor while the inputs are being rewritten. The first is provoked by sweeping small integer divisors against fractions from 0 to 63, including N = 1, where the carry and the tick coincide in almost every cycle. Every tick position is then compared with the closed-form position i·N + floor((i−1)·F/64). The second is provoked by changing the divisor inputs one cycle after `enable` rises. The tick positions must still follow the values that were captured, and the new values must take effect only after `enable` is lowered and raised again.

// File: rtl/btg_pkg.sv
package btg_pkg;
   localparam int unsigned BTG_INT_W_DEF  = 16;
   localparam int unsigned BTG_FRAC_W_DEF = 6;

   typedef enum logic [1:0] {
      BTG_IDLE = 2'd0,
      BTG_HALT = 2'd1,
      BTG_RUN  = 2'd2
   } btg_state_e;
endpackage

// File: rtl/btg_div_latch.sv
module btg_div_latch #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic [INT_W-1:0]  int_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              start_o,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o
);
   logic              en_q;
   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;

   assign start_o = enable_i & ~en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         int_q  <= '0;
         frac_q <= '0;
      end else begin
         en_q <= enable_i;
         if (start_o) begin
            int_q  <= int_i;
            frac_q <= frac_i;
         end
      end
   end

   // the capture cycle must use the live inputs, afterwards the held copy
   assign int_o  = start_o ? int_i  : int_q;
   assign frac_o = start_o ? frac_i : frac_q;
endmodule

// File: rtl/btg_frac_accum.sv
module btg_frac_accum #(
   parameter int unsigned FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              carry_o
);
   localparam int unsigned SUM_W = FRAC_W + 1;

   logic [FRAC_W-1:0] acc_q;
   logic [SUM_W-1:0]  sum;

   assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
   assign carry_o = sum[SUM_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (step_i)  acc_q <= sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/btg_interval_ctr.sv
module btg_interval_ctr
   import btg_pkg::*;
#(
   parameter int unsigned INT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             start_i,
   input  logic [INT_W-1:0] int_i,
   input  logic             carry_i,
   output logic             step_o,
   output logic             tick_o
);
   btg_state_e       st_q;
   logic [INT_W-1:0] cnt_q;
   logic [INT_W-1:0] reload;
   logic             expire;

   assign expire = (st_q == BTG_RUN) && (cnt_q == '0);
   assign step_o = enable_i && !start_i && expire;
   assign reload = int_i - INT_W'(1) + INT_W'(carry_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= BTG_IDLE;
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (!enable_i) begin
         st_q   <= BTG_IDLE;
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (start_i) begin
         tick_o <= 1'b0;
         if (int_i == '0) begin
            st_q  <= BTG_HALT;
            cnt_q <= '0;
         end else begin
            st_q  <= BTG_RUN;
            cnt_q <= int_i - INT_W'(1);
         end
      end else if (expire) begin
         tick_o <= 1'b1;
         cnt_q  <= reload;
      end else begin
         tick_o <= 1'b0;
         if (st_q == BTG_RUN) cnt_q <= cnt_q - INT_W'(1);
      end
   end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int unsigned INT_W  = btg_pkg::BTG_INT_W_DEF,
   parameter int unsigned FRAC_W = btg_pkg::BTG_FRAC_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);
   generate
      if (INT_W < 2 || INT_W > 32) begin : g_bad_int
         $error("frac_baud_gen: INT_W must lie in 2..32");
      end
      if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
         $error("frac_baud_gen: FRAC_W must lie in 1..16");
      end
   endgenerate

   logic              start;
   logic              step;
   logic              carry;
   logic [INT_W-1:0]  int_sel;
   logic [FRAC_W-1:0] frac_sel;

   btg_div_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) latch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable),
      .int_i    (div_int),
      .frac_i   (div_frac),
      .start_o  (start),
      .int_o    (int_sel),
      .frac_o   (frac_sel)
   );

   btg_frac_accum #(.FRAC_W(FRAC_W)) accum_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start | ~enable),
      .step_i  (step),
      .frac_i  (frac_sel),
      .carry_o (carry)
   );

   btg_interval_ctr #(.INT_W(INT_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable),
      .start_i  (start),
      .int_i    (int_sel),
      .carry_i  (carry),
      .step_o   (step),
      .tick_o   (tick)
   );
endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [INT_W-1:0]  div_int,
   input logic [FRAC_W-1:0] div_frac,
   input logic              tick
);
   logic             en_q;
   logic             first_q;
   logic [INT_W-1:0] cap_q;
   logic [INT_W:0]   gap_q;
   logic [INT_W:0]   cap_w;

   assign cap_w = {1'b0, cap_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         first_q <= 1'b1;
         cap_q   <= '0;
         gap_q   <= '0;
      end else begin
         en_q <= enable;
         if (enable && !en_q) begin
            cap_q   <= div_int;
            gap_q   <= '0;
            first_q <= 1'b1;
         end else if (tick) begin
            gap_q   <= (INT_W+1)'(1);
            first_q <= 1'b0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + (INT_W+1)'(1);
         end
      end
   end

   p_first_interval_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick && first_q) |-> (gap_q == cap_w));

   p_interval_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick && !first_q) |-> (gap_q == cap_w || gap_q == cap_w + 1'b1));

   p_no_missed_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cap_q != '0) |-> (gap_q <= cap_w + 1'b1));

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cap_q >= INT_W'(2) && tick) |=> !tick);

   p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !tick);

   p_zero_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cap_q == '0) |-> !tick);
endmodule

bind frac_baud_gen btg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .div_int  (div_int),
   .div_frac (div_frac),
   .tick     (tick)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb_top;
   localparam int INT_W  = 16;
   localparam int FRAC_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic [INT_W-1:0]  div_int = '0;
   logic [FRAC_W-1:0] div_frac = '0;
   logic              tick;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   frac_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .div_int(div_int), .div_frac(div_frac), .tick(tick)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // edge offset of tick i after the capture edge (R3 formula)
   function automatic int tpos(input int n, input int f, input int i);
      return i * n + ((i - 1) * f) / 64;
   endfunction

   // poke: rewrite the divisor inputs right after capture (R6)
   task automatic run_cfg(input int n, input int f, input int nticks, input bit poke);
      int nxt = 1;
      int t1 = 0;
      int t65 = 0;
      int lim;
      enable = 1'b0;
      @(negedge clk);
      @(negedge clk);
      div_int  = INT_W'(n);
      div_frac = FRAC_W'(f);
      enable   = 1'b1;
      @(negedge clk);
      if (poke) begin
         div_int  = INT_W'(n + 4);
         div_frac = FRAC_W'(f ^ 63);
      end
      check(tick == 1'b0, "R2 no tick in capture cycle", tick, 0);
      lim = tpos(n, f, nticks);
      for (int k = 1; k <= lim; k++) begin
         bit exp;
         @(negedge clk);
         exp = (k == tpos(n, f, nxt));
         if (nxt == 1)
            check(tick == exp, "R2 first tick position", tick, exp);
         else if (f == 0)
            check(tick == exp, "R9 integer period", tick, exp);
         else if (n == 1)
            check(tick == exp, "R10 unit divisor dither", tick, exp);
         else if (poke)
            check(tick == exp, "R6 captured divisor held", tick, exp);
         else
            check(tick == exp, "R3 dithered tick position", tick, exp);
         if (tick) begin
            if (nxt == 1)  t1  = k;
            if (nxt == 65) t65 = k;
            nxt++;
         end
      end
      if (nticks >= 65)
         check(t65 - t1 == 64 * n + f, "R4 span over 64 intervals", t65 - t1, 64 * n + f);
   endtask

   initial begin
      int ns [4] = '{1, 2, 3, 5};
      int fs [6] = '{0, 1, 8, 31, 32, 63};
      repeat (4) begin
         @(negedge clk);
         check(tick == 1'b0, "R1 low in reset", tick, 0);
      end
      rst_n = 1'b1;
      repeat (10) begin
         @(negedge clk);
         check(tick == 1'b0, "R1 low before enable", tick, 0);
      end

      // R3 R9 R10 R4: sweep of small divisors against fractions
      foreach (ns[a]) begin
         foreach (fs[b]) run_cfg(ns[a], fs[b], 66, 1'b0);
      end
      run_cfg(1, 16, 66, 1'b0);
      run_cfg(27, 8, 66, 1'b0);
      run_cfg(26, 3, 66, 1'b0);

      // R6: inputs changed while running, then applied on re-enable
      run_cfg(3, 5, 30, 1'b1);
      run_cfg(7, 58, 66, 1'b0);

      // R7: disable mid-run, then restart from a partly filled accumulator
      run_cfg(5, 37, 10, 1'b0);
      @(negedge clk);
      enable = 1'b0;
      repeat (20) begin
         @(negedge clk);
         check(tick == 1'b0, "R7 low while disabled", tick, 0);
      end
      run_cfg(5, 37, 66, 1'b0);

      // R8: zero integer part
      enable = 1'b0;
      @(negedge clk);
      div_int  = '0;
      div_frac = FRAC_W'(5);
      enable   = 1'b1;
      repeat (300) begin
         @(negedge clk);
         check(tick == 1'b0, "R8 zero divisor silent", tick, 0);
      end
      enable = 1'b0;

      summary();
      $finish;
   end
endmodule